// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel bytes into asynchronous serial frames on a single `tx` line. A byte written over the parallel port lands in a one-entry hold register. The shift register empties that register whenever it is free, so software can queue one byte while the previous one is still being shifted out. Each frame opens with a low start bit and closes with one high stop bit. Between them come the data bits, least significant bit first, and an optional parity bit.

The data width (8 or 7 bits), the parity enable and the parity sense are static inputs and can be changed while the block is idle. Two pacing modes exist:

- **Oversampled mode:** an internal divider gives 16 sub-ticks per bit, and the programmable divisor sets the spacing between sub-ticks.
- **Clock-rate mode:** each bit lasts exactly one system clock. This mode is for links where both ends share the clock.

Top module: `dbl_buf_serial_tx`

## Requirements
- R1: While and after an asynchronous reset (`rst_n` low), with no write, `tx` is 1 and `tx_ready` is 1.
- R2: A frame is, in line order: one start bit (0), the data bits with bit 0 first, the parity bit if enabled, then one stop bit (1). Afterwards the line returns to 1.
- R3: With `wide8` = 0 the frame carries data bits 0..6 only. Bit 7 of the written byte has no effect on the line, and the frame is one bit shorter.
- R4: With `par_on` = 1 a parity bit follows the last data bit. With `par_odd` = 1 the data bits plus parity hold an odd number of ones; with `par_odd` = 0 they hold an even number. Parity covers only the active data bits.
- R5: A write is accepted only on a rising clock edge where `wr_n` and `cs_n` are both 0. A strobe with only one of them low changes neither `tx` nor `tx_ready`.
- R6: A write to an idle block drops `tx_ready` for exactly the one cycle after the accepting edge. The start bit appears on `tx` after the next edge.
- R7: A byte written while a frame is in flight is held, and `tx_ready` stays 0 until it is taken. It is taken at the edge that ends the stop bit, and its start bit follows with no idle gap. `tx_ready` returns to 1 at that same edge.
- R8: A write attempted while the hold register is full is dropped: the queued byte is sent unchanged and nothing extra follows it.
- R9: In oversampled mode (`sync_mode` = 0) every bit lasts 16 × `baud_div` clocks, and a `baud_div` of 0 behaves as 1.
- R10: In clock-rate mode (`sync_mode` = 1) every bit lasts exactly one clock, whatever `baud_div` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 8 | Byte to transmit |
| wr_n | input | 1 | Write strobe, active low |
| cs_n | input | 1 | Select, active low; qualifies `wr_n` |
| tx_ready | output | 1 | High when the hold register can take a byte |
| wide8 | input | 1 | 1: eight data bits, 0: seven |
| par_on | input | 1 | 1: append a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| sync_mode | input | 1 | 1: one clock per bit, 0: oversampled pacing |
| baud_div | input | 8 | Clocks per sub-tick in oversampled mode |
| tx | output | 1 | Serial output, idles high |

## Verification
Two timing rules apply after a write at edge E0 to an idle block:

- `tx_ready` is low only in the cycle after E0.
- Bit k of the frame is on `tx` from edge E0+1+k·T to edge E0+1+(k+1)·T, where T is 1 in clock-rate mode and 16·max(`baud_div`,1) otherwise.

The bench samples at the falling edge and compares `tx` in every cycle of every bit window, so a bit that is early, late or short by even one clock is caught. A queued byte must begin exactly L·T cycles after the first start bit, where L is the frame length. That cycle is checked directly, with `tx_ready` held low throughout the first frame.

// File: rtl/dbl_buf_serial_tx_pkg.sv
package dbl_buf_serial_tx_pkg;

  typedef enum logic {
    SH_IDLE  = 1'b0,
    SH_SHIFT = 1'b1
  } shift_state_t;

endpackage

// File: rtl/dbl_buf_serial_tx_hold.sv
module dbl_buf_serial_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              cs_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              ready
);

  logic accept;

  assign accept = !wr_n && !cs_n && !full;
  assign ready  = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (accept) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R8: a write while full leaves the queued byte untouched
  a_r8_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take && !wr_n && !cs_n) |=> (full && $stable(data)));

  // R7: once the shifter takes the byte, the hold register is free
  a_r7_free_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ready);

endmodule

// File: rtl/dbl_buf_serial_tx_pace.sv
module dbl_buf_serial_tx_pace #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sync_mode,
  input  logic [DIV_W-1:0] div,
  output logic             step
);

  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic [SUB_W-1:0] sub;
  logic             tick;

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  assign lim  = eff_div(div);
  assign tick = run && (cnt == lim - DIV_W'(1));
  assign step = sync_mode ? run : (tick && (sub == SUB_W'(OVS - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sub <= '0;
    end else if (!run) begin
      cnt <= '0;
      sub <= '0;
    end else if (tick) begin
      cnt <= '0;
      sub <= (sub == SUB_W'(OVS - 1)) ? '0 : sub + SUB_W'(1);
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R9: with a divisor above one, sub-ticks never come on adjacent clocks
  a_r9_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (lim > DIV_W'(1))) |=> !tick);

  // R10: clock-rate mode advances every running cycle
  a_r10_sync_pace: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && run && !tick && (lim > DIV_W'(1))) |-> step);

endmodule

// File: rtl/dbl_buf_serial_tx_shift.sv
module dbl_buf_serial_tx_shift
  import dbl_buf_serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              wide8,
  input  logic              par_on,
  input  logic              par_odd,
  input  logic              step,
  output logic              busy,
  output logic              load,
  output logic              tx
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int LEFT_W  = $clog2(FRAME_W);

  shift_state_t     state;
  logic [FRAME_W-1:0] sr;
  logic [LEFT_W-1:0]  left;
  logic               last_bit;

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [DATA_W-1:0] d, input logic w8, input logic p_en, input logic p_odd);
    logic [FRAME_W-1:0] f;
    logic               p;
    int                 n;
    n    = w8 ? DATA_W : DATA_W - 1;
    f    = '1;
    f[0] = 1'b0;
    p    = p_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) begin
        f[i+1] = d[i];
        p      = p ^ d[i];
      end
    end
    if (p_en) f[n+1] = p;
    return f;
  endfunction

  function automatic logic [LEFT_W-1:0] last_index(input logic w8, input logic p_en);
    return LEFT_W'((w8 ? DATA_W : DATA_W - 1) + 1 + (p_en ? 1 : 0));
  endfunction

  assign busy     = (state == SH_SHIFT);
  assign last_bit = (left == '0);
  assign load     = hold_full && (!busy || (step && last_bit));
  assign tx       = busy ? sr[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SH_IDLE;
      sr    <= '1;
      left  <= '0;
    end else if (load) begin
      state <= SH_SHIFT;
      sr    <= build_frame(hold_data, wide8, par_on, par_odd);
      left  <= last_index(wide8, par_on);
    end else if (busy && step) begin
      if (last_bit) begin
        state <= SH_IDLE;
      end else begin
        sr   <= {1'b1, sr[FRAME_W-1:1]};
        left <= left - LEFT_W'(1);
      end
    end
  end

  // R2: a frame always opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tx);

  // R2: the final bit of every frame is the high stop bit
  a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_bit) |-> tx);

endmodule

// File: rtl/dbl_buf_serial_tx.sv
module dbl_buf_serial_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_n,
  input  logic              cs_n,
  output logic              tx_ready,
  input  logic              wide8,
  input  logic              par_on,
  input  logic              par_odd,
  input  logic              sync_mode,
  input  logic [DIV_W-1:0]  baud_div,
  output logic              tx
);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              busy;
  logic              step;

  dbl_buf_serial_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_n    (wr_n),
    .cs_n    (cs_n),
    .wr_data (wr_data),
    .take    (take),
    .full    (hold_full),
    .data    (hold_data),
    .ready   (tx_ready)
  );

  dbl_buf_serial_tx_pace #(.DIV_W(DIV_W), .OVS(OVS)) u_pace (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .sync_mode (sync_mode),
    .div       (baud_div),
    .step      (step)
  );

  dbl_buf_serial_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .wide8     (wide8),
    .par_on    (par_on),
    .par_odd   (par_odd),
    .step      (step),
    .busy      (busy),
    .load      (take),
    .tx        (tx)
  );

  // R6: an idle shifter picks up a queued byte at the next edge
  a_r6_idle_pickup: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tx_ready) |=> (busy && tx_ready));

endmodule

// File: tb/dbl_buf_serial_tx_test.sv
`timescale 1ns/1ps
module dbl_buf_serial_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_n = 1'b1;
  logic       cs_n = 1'b1;
  logic       tx_ready;
  logic       wide8 = 1'b1;
  logic       par_on = 1'b0;
  logic       par_odd = 1'b0;
  logic       sync_mode = 1'b1;
  logic [7:0] baud_div = 8'd1;
  logic       tx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbl_buf_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_n(wr_n), .cs_n(cs_n),
    .tx_ready(tx_ready), .wide8(wide8), .par_on(par_on), .par_odd(par_odd),
    .sync_mode(sync_mode), .baud_div(baud_div), .tx(tx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nbits();
    return 2 + (wide8 ? 8 : 7) + (par_on ? 1 : 0);
  endfunction

  function automatic int bit_time();
    if (sync_mode) return 1;
    return 16 * ((baud_div == 0) ? 1 : int'(baud_div));
  endfunction

  function automatic logic exp_bit(input logic [7:0] d, input int k);
    int w;
    int ones;
    w = wide8 ? 8 : 7;
    ones = 0;
    for (int i = 0; i < w; i++) ones += d[i];
    if (k == 0) return 1'b0;
    if (k <= w) return d[k-1];
    if (par_on && k == w + 1) return par_odd ? logic'((ones + 1) % 2) : logic'(ones % 2);
    return 1'b1;
  endfunction

  task automatic step_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input logic [7:0] d, input logic w, input logic c);
    wr_data = d; wr_n = w; cs_n = c;
    step_cycle();
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  // Called at the falling edge inside cycle 'start' of the frame; returns at the
  // falling edge of the first cycle after the frame.
  task automatic expect_frame(input logic [7:0] d, input int start, input logic rdy,
                              input string tag);
    int  bt;
    int  len;
    bt  = bit_time();
    len = nbits();
    for (int k = 0; k < len; k++) begin
      logic e;
      bit   bad;
      bit   rbad;
      logic got;
      bit   seen;
      e = exp_bit(d, k);
      bad = 0; rbad = 0; got = e; seen = 0;
      for (int c = 0; c < bt; c++) begin
        if (k * bt + c >= start) begin
          seen = 1;
          if (tx !== e && !bad) begin bad = 1; got = tx; end
          if (tx_ready !== rdy) rbad = 1;
          step_cycle();
        end
      end
      if (seen) begin
        chk(!bad, $sformatf("%s bit%0d", tag, k), int'(got), int'(e));
        if (rbad) chk(0, "R7 tx_ready during frame", int'(!rdy), int'(rdy));
      end
    end
  endtask

  task automatic send_one(input logic [7:0] d, input string tag);
    strobe(d, 1'b0, 1'b0);
    chk(tx_ready === 1'b0, "R6 ready dip", int'(tx_ready), 0);
    chk(tx === 1'b1, "R6 line idle before start", int'(tx), 1);
    step_cycle();
    chk(tx_ready === 1'b1, "R6 ready back after one cycle", int'(tx_ready), 1);
    expect_frame(d, 0, 1'b1, tag);
    chk(tx === 1'b1, "R2 idle after stop", int'(tx), 1);
  endtask

  task automatic back_to_back(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    strobe(a, 1'b0, 1'b0);
    step_cycle();
    strobe(b, 1'b0, 1'b0);
    chk(tx_ready === 1'b0, "R7 ready low with byte queued", int'(tx_ready), 0);
    strobe(c, 1'b0, 1'b0);
    expect_frame(a, 2, 1'b0, "R7 first frame");
    expect_frame(b, 0, 1'b1, "R7 queued frame no gap");
    for (int i = 0; i < 3 * bit_time(); i++) begin
      if (tx !== 1'b1 || tx_ready !== 1'b1) begin
        chk(0, "R8 dropped byte sent", int'(tx), 1);
        break;
      end
      step_cycle();
    end
    chk(tx === 1'b1, "R8 line idle after queued frame", int'(tx), 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step_cycle();
    chk(tx === 1'b1, "R1 tx in reset", int'(tx), 1);
    chk(tx_ready === 1'b1, "R1 ready in reset", int'(tx_ready), 1);
    rst_n = 1'b1;
    step_cycle();
    chk(tx === 1'b1 && tx_ready === 1'b1, "R1 after reset", int'({tx, tx_ready}), 3);

    // R5: half-qualified strobes do nothing
    strobe(8'h00, 1'b0, 1'b1);
    chk(tx_ready === 1'b1, "R5 cs high ignored", int'(tx_ready), 1);
    strobe(8'h00, 1'b1, 1'b0);
    chk(tx_ready === 1'b1, "R5 wr high ignored", int'(tx_ready), 1);
    for (int i = 0; i < 4; i++) begin
      chk(tx === 1'b1, "R5 line stays idle", int'(tx), 1);
      step_cycle();
    end

    // R10 with R2, R3 and R4: sweep every byte over every format, one clock per bit
    sync_mode = 1'b1;
    baud_div = 8'd7;
    for (int cfg = 0; cfg < 8; cfg++) begin
      wide8 = cfg[0]; par_on = cfg[1]; par_odd = cfg[2];
      for (int d = 0; d < 256; d++) begin
        send_one(8'(d), !wide8 ? "R3 seven-bit R10" : (par_on ? "R4 parity R10" : "R2 frame R10"));
      end
    end

    // R9: oversampled pacing, including a zero divisor
    sync_mode = 1'b0;
    for (int dv = 0; dv < 4; dv++) begin
      baud_div = 8'(dv);
      for (int cfg = 0; cfg < 4; cfg++) begin
        wide8 = cfg[0]; par_on = cfg[1]; par_odd = cfg[0] ^ cfg[1];
        send_one(8'hA5, "R9 oversampled");
        send_one(8'h3C, "R9 oversampled");
      end
    end

    // R7 and R8: queued byte, dropped third write
    wide8 = 1'b1; par_on = 1'b1; par_odd = 1'b1;
    sync_mode = 1'b1;
    back_to_back(8'h96, 8'h5B, 8'hFF);
    sync_mode = 1'b0; baud_div = 8'd2;
    back_to_back(8'h81, 8'h7E, 8'h00);
    wide8 = 1'b0; par_on = 1'b0;
    back_to_back(8'hC3, 8'h80, 8'h55);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule